// File: doc/BRIEF.md
# Control Endpoint Status Register Bank

This block keeps the two status registers of a USB device's control endpoint and enforces the rules that keep firmware and the serial interface engine from overwriting each other. It sits between a CPU I/O bus and the engine. The CPU reads and writes through single-cycle strobes. The engine reports transaction events as one-cycle pulses.

The mode register holds a four-bit response mode, an ACK-completed flag and a SETUP-received flag. Whenever the engine changes the lower seven bits, CPU writes to those bits are locked out until the CPU reads the register. While the SETUP flag is set, CPU writes to the endpoint FIFO are blocked. This stops firmware from overwriting SETUP data it has not read yet. The counter register holds the byte count, a data-valid flag and the data toggle. The engine writes it on reception; firmware loads it before IN transfers.

Blocked writes are dropped silently and still acknowledged. Firmware detects a dropped write by reading the register back.

Top module: `ep0_status_bank`

## Requirements
- R1: After reset the mode register and the counter register both read 0x00, and the lower mode bits are unlocked.
- R2: An unlocked CPU write to the mode address stores data bits 3:0 as the mode and data bit 4 as the ACK flag. Bits 6:5 always read 0.
- R3: Each engine update of the lower seven mode bits sets the lock. The updates are a mode load at token end, or an ACK completion. While locked, CPU writes to bits 6:0 are dropped and the CPU strobe is still acknowledged.
- R4: A CPU read of the mode register clears the lock. If an engine update arrives in the same cycle as the read, the lock stays set.
- R5: At token end the SETUP flag (mode bit 7) takes the token type: 1 for a SETUP token, 0 for any other token.
- R6: Any CPU write to the mode address clears bit 7, even while the lower bits are locked, except during the hold window of R7.
- R7: A data-phase start while bit 7 is 1 opens a hold window. The window closes at the ACK-packet start. Inside the window, bit 7 stays 1 whatever the CPU writes.
- R8: A CPU write inside the FIFO address window asserts the FIFO write enable, with the offset and data, only while bit 7 is 0. Otherwise the write is dropped.
- R9: A completed ACK transaction sets mode bit 4.
- R10: An engine count write stores the received byte count plus 2, saturating at MAX_PKT+2, in bits 5:0. It stores the data-valid flag in bit 6 and the toggle in bit 7.
- R11: A CPU counter write stores bits 7:6 as given and the count clamped to MAX_PKT.
- R12: Every CPU strobe is acknowledged in the next cycle. Read data comes with the acknowledge, and unmapped addresses read 0.
- R13: When a CPU write and an engine update of the lower mode bits land in the same cycle, the engine value is kept and the CPU value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | CPU I/O address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_ack after a read |
| cpu_ack | output | 1 | Strobe acknowledge, one cycle after the strobe |
| sie_token_end | input | 1 | End of token phase |
| sie_setup_tok | input | 1 | Token at token end was SETUP |
| sie_mode_upd | input | 1 | Load sie_mode at token end |
| sie_mode | input | 4 | Mode value from the engine |
| sie_data_start | input | 1 | Start of data packet phase |
| sie_ack_start | input | 1 | Start of returned ACK packet |
| sie_ack_done | input | 1 | Transaction completed with ACK |
| sie_cnt_we | input | 1 | Engine counter write |
| sie_rx_bytes | input | 6 | Received data bytes |
| sie_data_valid | input | 1 | Received data valid flag |
| sie_toggle | input | 1 | Data 0/1 toggle |
| fifo_we | output | 1 | Gated FIFO write enable |
| fifo_waddr | output | FIFO_AW | FIFO write offset |
| fifo_wdata | output | 8 | FIFO write data |

## Verification
The bench builds the block with the default parameters: MAX_PKT 32, an 8-entry FIFO window aligned at address 0x00, and CPU count clamping enabled. With these values both count ceilings can be reached: a 40-byte engine report saturates at 34, and a CPU load of 63 clamps to 32. The aligned window selects the bit-slice decoder. The small window puts offset 3 and the window's edge within a few strobes.

// File: rtl/ep0_bank_pkg.sv
package ep0_bank_pkg;

   localparam int REG_W  = 8;
   localparam int CNT_W  = 6;
   localparam int MODE_W = 4;

   typedef struct packed {
      logic              setup;
      logic [1:0]        rsvd;
      logic              ack;
      logic [MODE_W-1:0] mode;
   } ep0_mode_t;

   typedef struct packed {
      logic             toggle;
      logic             valid;
      logic [CNT_W-1:0] count;
   } ep0_cnt_t;

endpackage

// File: rtl/ep0_mode_reg.sv
module ep0_mode_reg
   import ep0_bank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [4:0]        cpu_wdata,
   input  logic              token_end,
   input  logic              setup_tok,
   input  logic              mode_upd,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              data_start,
   input  logic              ack_start,
   input  logic              ack_done,
   output ep0_mode_t         mode_q,
   output logic              setup_o
);

   logic lock_q;
   logic hold_q;
   logic sie_low_upd;
   logic cpu_low_ok;

   assign sie_low_upd = (token_end && mode_upd) || ack_done;
   assign cpu_low_ok  = cpu_wr && !lock_q && !sie_low_upd;
   assign setup_o     = mode_q.setup;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         lock_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (hold_q)         mode_q.setup <= 1'b1;
         else if (token_end) mode_q.setup <= setup_tok;
         else if (cpu_wr)    mode_q.setup <= 1'b0;

         if (sie_low_upd) begin
            if (token_end && mode_upd) mode_q.mode <= mode_in;
            if (ack_done)              mode_q.ack  <= 1'b1;
         end else if (cpu_low_ok) begin
            mode_q.mode <= cpu_wdata[MODE_W-1:0];
            mode_q.ack  <= cpu_wdata[4];
         end
         mode_q.rsvd <= '0;

         if (sie_low_upd) lock_q <= 1'b1;
         else if (cpu_rd) lock_q <= 1'b0;

         if (ack_start)                       hold_q <= 1'b0;
         else if (data_start && mode_q.setup) hold_q <= 1'b1;
      end
   end

   AST_SIE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      sie_low_upd |=> lock_q); // R3

   AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !sie_low_upd) |=> $stable({mode_q.ack, mode_q.mode})); // R3

   AST_READ_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !sie_low_upd) |=> !lock_q); // R4

   AST_HOLD_KEEPS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |=> mode_q.setup); // R7

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr |=> (mode_q.rsvd == 2'b00)); // R2

endmodule

// File: rtl/ep0_count_reg.sv
module ep0_count_reg
   import ep0_bank_pkg::*;
#(
   parameter int MAX_PKT   = 32,
   parameter bit CLAMP_CPU = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_wr,
   input  logic [REG_W-1:0] cpu_wdata,
   input  logic             sie_we,
   input  logic [CNT_W-1:0] rx_bytes,
   input  logic             rx_valid,
   input  logic             rx_toggle,
   output ep0_cnt_t         cnt_q
);

   localparam int            CRC_BYTES = 2;
   localparam int            RX_CEIL   = MAX_PKT + CRC_BYTES;
   localparam logic [CNT_W:0] RX_CEIL_V = (CNT_W+1)'(RX_CEIL);
   localparam logic [CNT_W-1:0] TX_CEIL_V = CNT_W'(MAX_PKT);

   if (RX_CEIL > (1 << CNT_W) - 1) begin : g_bad_max
      $error("MAX_PKT too large for the count field");
   end

   logic [CNT_W:0]   rx_sum;
   logic [CNT_W-1:0] rx_cnt;
   logic [CNT_W-1:0] tx_cnt;

   assign rx_sum = {1'b0, rx_bytes} + (CNT_W+1)'(CRC_BYTES);
   assign rx_cnt = (rx_sum > RX_CEIL_V) ? RX_CEIL_V[CNT_W-1:0] : rx_sum[CNT_W-1:0];

   if (CLAMP_CPU) begin : g_clamp
      assign tx_cnt = (cpu_wdata[CNT_W-1:0] > TX_CEIL_V) ? TX_CEIL_V : cpu_wdata[CNT_W-1:0];

      AST_CPU_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_wr && !sie_we) |=> (cnt_q.count <= TX_CEIL_V)); // R11
   end else begin : g_pass
      assign tx_cnt = cpu_wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (sie_we) begin
         cnt_q.count  <= rx_cnt;
         cnt_q.valid  <= rx_valid;
         cnt_q.toggle <= rx_toggle;
      end else if (cpu_wr) begin
         cnt_q.count  <= tx_cnt;
         cnt_q.valid  <= cpu_wdata[6];
         cnt_q.toggle <= cpu_wdata[7];
      end
   end

   AST_RX_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      sie_we |=> ({1'b0, cnt_q.count} <= RX_CEIL_V)); // R10

endmodule

// File: rtl/ep0_fifo_gate.sv
module ep0_fifo_gate #(
   parameter int ADDR_W     = 8,
   parameter int FIFO_BASE  = 0,
   parameter int FIFO_DEPTH = 8,
   parameter int FIFO_AW    = $clog2(FIFO_DEPTH)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic               cpu_wr,
   input  logic               setup_i,
   output logic               fifo_hit,
   output logic               fifo_we,
   output logic [FIFO_AW-1:0] fifo_waddr
);

   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(FIFO_BASE);
   localparam logic [ADDR_W:0]   END_V  = (ADDR_W+1)'(FIFO_BASE + FIFO_DEPTH);
   localparam bit POW2    = (FIFO_DEPTH & (FIFO_DEPTH - 1)) == 0;
   localparam bit ALIGNED = POW2 && ((FIFO_BASE % FIFO_DEPTH) == 0);

   if (FIFO_DEPTH < 2 || FIFO_AW >= ADDR_W) begin : g_bad_depth
      $error("FIFO window size out of range");
   end

   if (ALIGNED) begin : g_slice
      assign fifo_hit   = (cpu_addr[ADDR_W-1:FIFO_AW] == BASE_V[ADDR_W-1:FIFO_AW]);
      assign fifo_waddr = cpu_addr[FIFO_AW-1:0];
   end else begin : g_range
      logic [ADDR_W-1:0] diff;
      assign diff       = cpu_addr - BASE_V;
      assign fifo_hit   = (cpu_addr >= BASE_V) && ({1'b0, cpu_addr} < END_V);
      assign fifo_waddr = diff[FIFO_AW-1:0];
   end

   assign fifo_we = cpu_wr && fifo_hit && !setup_i;

   AST_FIFO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      setup_i |-> !fifo_we); // R8

   AST_FIFO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && fifo_hit && !setup_i) |-> fifo_we); // R8

endmodule

// File: rtl/ep0_status_bank.sv
module ep0_status_bank
   import ep0_bank_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int MODE_ADDR  = 'h11,
   parameter int CNT_ADDR   = 'h10,
   parameter int FIFO_BASE  = 'h00,
   parameter int FIFO_DEPTH = 8,
   parameter int MAX_PKT    = 32,
   parameter bit CLAMP_CPU  = 1'b1,
   parameter int FIFO_AW    = $clog2(FIFO_DEPTH)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic               cpu_wr,
   input  logic               cpu_rd,
   input  logic [7:0]         cpu_wdata,
   output logic [7:0]         cpu_rdata,
   output logic               cpu_ack,
   input  logic               sie_token_end,
   input  logic               sie_setup_tok,
   input  logic               sie_mode_upd,
   input  logic [3:0]         sie_mode,
   input  logic               sie_data_start,
   input  logic               sie_ack_start,
   input  logic               sie_ack_done,
   input  logic               sie_cnt_we,
   input  logic [5:0]         sie_rx_bytes,
   input  logic               sie_data_valid,
   input  logic               sie_toggle,
   output logic               fifo_we,
   output logic [FIFO_AW-1:0] fifo_waddr,
   output logic [7:0]         fifo_wdata
);

   localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
   localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_ADDR);

   if (MODE_ADDR == CNT_ADDR) begin : g_bad_map
      $error("mode and counter addresses collide");
   end
   if ((MODE_ADDR >= FIFO_BASE && MODE_ADDR < FIFO_BASE + FIFO_DEPTH) ||
       (CNT_ADDR  >= FIFO_BASE && CNT_ADDR  < FIFO_BASE + FIFO_DEPTH)) begin : g_bad_win
      $error("register address inside FIFO window");
   end

   logic      hit_mode, hit_cnt, fifo_hit, setup_w;
   ep0_mode_t mode_w;
   ep0_cnt_t  cnt_w;

   assign hit_mode = (cpu_addr == MODE_A);
   assign hit_cnt  = (cpu_addr == CNT_A);

   ep0_mode_reg u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_wr     (cpu_wr && hit_mode),
      .cpu_rd     (cpu_rd && hit_mode),
      .cpu_wdata  (cpu_wdata[4:0]),
      .token_end  (sie_token_end),
      .setup_tok  (sie_setup_tok),
      .mode_upd   (sie_mode_upd),
      .mode_in    (sie_mode),
      .data_start (sie_data_start),
      .ack_start  (sie_ack_start),
      .ack_done   (sie_ack_done),
      .mode_q     (mode_w),
      .setup_o    (setup_w)
   );

   ep0_count_reg #(
      .MAX_PKT   (MAX_PKT),
      .CLAMP_CPU (CLAMP_CPU)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr && hit_cnt),
      .cpu_wdata (cpu_wdata),
      .sie_we    (sie_cnt_we),
      .rx_bytes  (sie_rx_bytes),
      .rx_valid  (sie_data_valid),
      .rx_toggle (sie_toggle),
      .cnt_q     (cnt_w)
   );

   ep0_fifo_gate #(
      .ADDR_W     (ADDR_W),
      .FIFO_BASE  (FIFO_BASE),
      .FIFO_DEPTH (FIFO_DEPTH),
      .FIFO_AW    (FIFO_AW)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_addr   (cpu_addr),
      .cpu_wr     (cpu_wr),
      .setup_i    (setup_w),
      .fifo_hit   (fifo_hit),
      .fifo_we    (fifo_we),
      .fifo_waddr (fifo_waddr)
   );

   assign fifo_wdata = cpu_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_ack   <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         cpu_ack <= cpu_wr || cpu_rd;
         if (cpu_rd) begin
            if (hit_mode)     cpu_rdata <= mode_w;
            else if (hit_cnt) cpu_rdata <= cnt_w;
            else              cpu_rdata <= '0;
         end
      end
   end

   AST_STROBE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr || cpu_rd) |=> cpu_ack); // R12

   AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_wr && !cpu_rd) |=> !cpu_ack); // R12

   AST_FIFO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_we |-> (fifo_hit && !hit_mode && !hit_cnt)); // R8

endmodule

// File: tb/ep0_status_bank_tb.sv
module ep0_status_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_MODE = 8'h11;
   localparam logic [7:0] A_CNT  = 8'h10;

   typedef struct {
      bit         is_rd;
      logic [7:0] exp;
      string      tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cpu_addr = '0;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       cpu_ack;
   logic       sie_token_end = 0, sie_setup_tok = 0, sie_mode_upd = 0;
   logic [3:0] sie_mode = '0;
   logic       sie_data_start = 0, sie_ack_start = 0, sie_ack_done = 0;
   logic       sie_cnt_we = 0, sie_data_valid = 0, sie_toggle = 0;
   logic [5:0] sie_rx_bytes = '0;
   logic       fifo_we;
   logic [2:0] fifo_waddr;
   logic [7:0] fifo_wdata;

   int    tests = 0;
   int    fails = 0;
   bit    done  = 1'b0;
   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ep0_status_bank u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
      .sie_token_end(sie_token_end), .sie_setup_tok(sie_setup_tok),
      .sie_mode_upd(sie_mode_upd), .sie_mode(sie_mode),
      .sie_data_start(sie_data_start), .sie_ack_start(sie_ack_start),
      .sie_ack_done(sie_ack_done), .sie_cnt_we(sie_cnt_we),
      .sie_rx_bytes(sie_rx_bytes), .sie_data_valid(sie_data_valid),
      .sie_toggle(sie_toggle), .fifo_we(fifo_we), .fifo_waddr(fifo_waddr),
      .fifo_wdata(fifo_wdata)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: each acknowledge pops one scoreboard item (R12)
   always @(negedge clk) begin
      if (rst_n && cpu_ack) begin
         if (sb_q.size() == 0) begin
            check("R12 ack without strobe", 1, 0);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            if (it.is_rd) check(it.tag, cpu_rdata, it.exp);
            else          check({it.tag, " ack"}, cpu_ack, 1);
         end
      end
   end

   task automatic cpu_write(logic [7:0] a, logic [7:0] d, string tag);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      sb_q.push_back('{is_rd: 1'b0, exp: 8'h00, tag: tag});
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_read(logic [7:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      cpu_addr = a; cpu_rd = 1'b1;
      sb_q.push_back('{is_rd: 1'b1, exp: exp, tag: tag});
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic fifo_write(logic [7:0] a, logic [7:0] d, bit exp_we, string tag);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      sb_q.push_back('{is_rd: 1'b0, exp: 8'h00, tag: tag});
      #1;
      check(tag, fifo_we, exp_we);
      if (exp_we) begin
         check({tag, " offset"}, fifo_waddr, a[2:0]);
         check({tag, " data"}, fifo_wdata, d);
      end
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic token(bit is_setup, bit upd, logic [3:0] m);
      @(negedge clk);
      sie_token_end = 1'b1; sie_setup_tok = is_setup; sie_mode_upd = upd; sie_mode = m;
      @(negedge clk);
      sie_token_end = 1'b0; sie_mode_upd = 1'b0;
   endtask

   task automatic pulse_data_start();
      @(negedge clk); sie_data_start = 1'b1;
      @(negedge clk); sie_data_start = 1'b0;
   endtask

   task automatic pulse_ack_start();
      @(negedge clk); sie_ack_start = 1'b1;
      @(negedge clk); sie_ack_start = 1'b0;
   endtask

   task automatic pulse_ack_done();
      @(negedge clk); sie_ack_done = 1'b1;
      @(negedge clk); sie_ack_done = 1'b0;
   endtask

   task automatic sie_count(logic [5:0] rx, bit v, bit t);
      @(negedge clk);
      sie_cnt_we = 1'b1; sie_rx_bytes = rx; sie_data_valid = v; sie_toggle = t;
      @(negedge clk);
      sie_cnt_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cpu_read(A_MODE, 8'h00, "R1 mode reset");
      cpu_read(A_CNT,  8'h00, "R1 counter reset");
      cpu_write(A_MODE, 8'h13, "R1 unlocked after reset");
      cpu_read(A_MODE, 8'h13, "R1 write accepted after reset");

      // R2 unlocked write, reserved bits read 0
      cpu_write(A_MODE, 8'h7F, "R2 write all");
      cpu_read(A_MODE, 8'h1F, "R2 reserved bits zero");
      cpu_write(A_MODE, 8'h03, "R2 write mode 3");
      cpu_read(A_MODE, 8'h03, "R2 mode 3");

      // R3 lock after engine mode load; R4 read unlocks
      token(1'b0, 1'b1, 4'h9);
      cpu_write(A_MODE, 8'h02, "R3 locked write");
      cpu_read(A_MODE, 8'h09, "R3 locked write dropped");
      cpu_write(A_MODE, 8'h02, "R4 write after read");
      cpu_read(A_MODE, 8'h02, "R4 unlocked by read");

      // R5 setup token, R8 FIFO blocked, R7 hold
      token(1'b1, 1'b1, 4'h1);
      cpu_read(8'h20, 8'h00, "R12 unmapped read");
      fifo_write(8'h03, 8'hA5, 1'b0, "R8 FIFO blocked by setup");
      pulse_data_start();
      cpu_write(A_MODE, 8'h00, "R7 write in hold");
      cpu_read(A_MODE, 8'h81, "R5 R7 setup held and lock kept");
      cpu_write(A_MODE, 8'h00, "R7 unlocked write in hold");
      cpu_read(A_MODE, 8'h80, "R7 setup still held");
      pulse_ack_start();
      pulse_ack_done();
      cpu_read(A_MODE, 8'h90, "R9 ACK bit set");
      cpu_write(A_MODE, 8'h04, "R6 clear setup");
      cpu_read(A_MODE, 8'h04, "R6 setup cleared");
      fifo_write(8'h03, 8'h5A, 1'b1, "R8 FIFO write passes");
      fifo_write(8'h07, 8'h11, 1'b1, "R8 FIFO last slot");
      fifo_write(8'h08, 8'h22, 1'b0, "R8 outside FIFO window");

      // R6 clear while locked
      token(1'b1, 1'b1, 4'h2);
      cpu_write(A_MODE, 8'h0F, "R6 write when locked");
      cpu_read(A_MODE, 8'h02, "R6 setup cleared lower kept");
      token(1'b0, 1'b0, 4'hF);
      cpu_read(A_MODE, 8'h02, "R5 non-setup token no load");

      // R13 same-cycle CPU write and engine load
      @(negedge clk);
      cpu_addr = A_MODE; cpu_wdata = 8'h05; cpu_wr = 1'b1;
      sie_token_end = 1'b1; sie_setup_tok = 1'b0; sie_mode_upd = 1'b1; sie_mode = 4'h6;
      sb_q.push_back('{is_rd: 1'b0, exp: 8'h00, tag: "R13 collide"});
      @(negedge clk);
      cpu_wr = 1'b0; sie_token_end = 1'b0; sie_mode_upd = 1'b0;
      cpu_read(A_MODE, 8'h06, "R13 engine wins");

      // R4 read colliding with engine update keeps the lock
      @(negedge clk);
      cpu_addr = A_MODE; cpu_rd = 1'b1; sie_ack_done = 1'b1;
      sb_q.push_back('{is_rd: 1'b1, exp: 8'h06, tag: "R4 read old value"});
      @(negedge clk);
      cpu_rd = 1'b0; sie_ack_done = 1'b0;
      cpu_write(A_MODE, 8'h01, "R4 write while still locked");
      cpu_read(A_MODE, 8'h16, "R4 lock survived collision");

      // counter register
      sie_count(6'd8, 1'b1, 1'b1);
      cpu_read(A_CNT, 8'hCA, "R10 rx count plus 2");
      sie_count(6'd40, 1'b0, 1'b0);
      cpu_read(A_CNT, 8'h22, "R10 rx saturates at 34");
      cpu_write(A_CNT, 8'h7F, "R11 write over max");
      cpu_read(A_CNT, 8'h60, "R11 clamp to 32");
      cpu_write(A_CNT, 8'h95, "R11 write 21");
      cpu_read(A_CNT, 8'h95, "R11 stored as given");
      @(negedge clk);
      cpu_addr = A_CNT; cpu_wdata = 8'h9F; cpu_wr = 1'b1;
      sie_cnt_we = 1'b1; sie_rx_bytes = 6'd0; sie_data_valid = 1'b1; sie_toggle = 1'b0;
      sb_q.push_back('{is_rd: 1'b0, exp: 8'h00, tag: "R10 collide"});
      @(negedge clk);
      cpu_wr = 1'b0; sie_cnt_we = 1'b0;
      cpu_read(A_CNT, 8'h42, "R10 engine count wins");
      cpu_read(8'h02, 8'h00, "R12 FIFO address reads 0");

      repeat (4) @(negedge clk);
      check("R12 scoreboard drained", sb_q.size(), 0);
      finish_run();
   end

endmodule